// File: doc/BRIEF.md
# Load-Store Effective Address Generator

This block forms the 32-bit memory address for the load and store operands of a 32-bit processor with sixteen general registers. Register 0 also serves as the stack pointer and needs no special handling. Each request carries an addressing mode, an access width code, an instruction class, the index of the base register, the base and index register values from a read port, and a raw 16-bit displacement field. One clock later the block returns the effective address and a misalignment flag. For the auto-modify modes it also returns a write-back request that carries the updated base register value.

The supported modes are plain register indirect, base plus a scaled displacement of 5, 8 or 16 bits, post-increment, pre-decrement, and base plus a scaled index. How much the displacement is scaled depends on the instruction class as well as on the width code. The auto-modify and indexed modes always scale by the access width. An illegal-operand flag marks two cases: the short 5-bit form used with a base register above 7, and the reserved mode code.

Top module: `lsu_ea_gen`

## Requirements
- R1: While `rst_ni` is low, and on the first sampling after it, `out_valid_o`, `wb_en_o`, `misalign_o` and `illegal_o` are 0.
- R2: Every result belongs to the request presented on the previous rising clock edge. `out_valid_o` equals `req_valid_i` delayed by one cycle. When `out_valid_o` is 0, the flags `wb_en_o`, `misalign_o` and `illegal_o` are also 0.
- R3: Mode code 0 (register indirect) gives an address equal to `base_val_i`, unchanged.
- R4: Mode 2 uses the low 8 bits of `disp_i` and mode 3 uses all 16 bits. The displacement is zero-extended, shifted left by a scale and added to `base_val_i` modulo 2^32. The scale is set by the class:
  - class 0 (transfer) and class 1 (arithmetic with size extension) scale by the access width;
  - class 2 (bit manipulation) scales by 1;
  - class 3 (other) scales by 4.
  Width codes 0 (signed byte) and 1 (unsigned byte) give width 1, codes 2 (signed word) and 3 (unsigned word) give width 2, and codes 4 to 7 give width 4.
- R5: Mode 1 (short relative) uses the low 5 bits of `disp_i`, zero-extended and scaled by the access width, as the offset from the base register. If `base_idx_i` is above 7, `illegal_o` is set, no write-back is requested, and the address is undefined.
- R6: Mode 4 (post-increment) gives the unmodified base as the address. It sets `wb_en_o`, with `wb_data_o` equal to the base plus the access width modulo 2^32.
- R7: Mode 5 (pre-decrement) gives the base minus the access width modulo 2^32. That value appears on both `ea_o` and `wb_data_o`, and `wb_en_o` is set.
- R8: Mode 6 (indexed) gives the low 32 bits of `base_val_i` plus `index_val_i` shifted left by the log2 of the access width.
- R9: `misalign_o` is 1 for a width-2 access at an odd address, and for a width-4 access whose address has either of its two low bits set. It is 0 for any width-1 access.
- R10: Only modes 4 and 5 set `wb_en_o`, and `wb_idx_o` then repeats `base_idx_i`. `index_val_i` has no effect on the address outside mode 6.
- R11: Mode code 7 is reserved. It sets `illegal_o` and requests no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| req_valid_i | input | 1 | A request is present this cycle |
| mode_i | input | 3 | Addressing mode code (0 to 7) |
| iclass_i | input | 2 | Instruction class (0 transfer, 1 extended arithmetic, 2 bit, 3 other) |
| wcode_i | input | 3 | Access width or extension code |
| base_idx_i | input | 4 | Index of the base register |
| base_val_i | input | 32 | Base register value |
| index_val_i | input | 32 | Index register value |
| disp_i | input | 16 | Raw displacement field |
| out_valid_o | output | 1 | Results below are for last cycle's request |
| ea_o | output | 32 | Effective address |
| wb_en_o | output | 1 | Write the updated base register back |
| wb_idx_o | output | 4 | Register to write back |
| wb_data_o | output | 32 | Updated base register value |
| misalign_o | output | 1 | Address not a multiple of the access width |
| illegal_o | output | 1 | Illegal operand (short form register above 7, or reserved mode) |

## Verification
Every result goes through exactly one register. The address, write-back request, misalignment and illegal flags for a request sampled at one rising edge are therefore all due together at the following edge. The bench drives inputs on the falling edge and reads all outputs on the next falling edge, half a cycle after they change. The vector loop sends requests back to back, with no idle cycle, so each check also confirms that one result does not leak into the next. The directed tests then drop `req_valid_i` and check at the same distance that `out_valid_o` and the flags have cleared.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [2:0] {
    MODE_IND     = 3'd0,
    MODE_REL5    = 3'd1,
    MODE_REL8    = 3'd2,
    MODE_REL16   = 3'd3,
    MODE_POSTINC = 3'd4,
    MODE_PREDEC  = 3'd5,
    MODE_INDEXED = 3'd6,
    MODE_RSVD    = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    CLS_XFER  = 2'd0,
    CLS_ARITH = 2'd1,
    CLS_BIT   = 2'd2,
    CLS_OTHER = 2'd3
  } iclass_e;

  typedef enum logic [2:0] {
    WC_SB = 3'd0,
    WC_UB = 3'd1,
    WC_SW = 3'd2,
    WC_UW = 3'd3,
    WC_L  = 3'd4
  } wcode_e;

  // log2 of the access width in bytes for a width/extension code
  function automatic logic [1:0] access_log2(input logic [2:0] wc);
    case (wc)
      WC_SB, WC_UB: access_log2 = 2'd0;
      WC_SW, WC_UW: access_log2 = 2'd1;
      default:      access_log2 = 2'd2;
    endcase
  endfunction

  // log2 of the displacement scale for the 8/16-bit relative forms
  function automatic logic [1:0] disp_log2(input logic [1:0] cls, input logic [2:0] wc);
    case (cls)
      CLS_XFER, CLS_ARITH: disp_log2 = access_log2(wc);
      CLS_BIT:             disp_log2 = 2'd0;
      default:             disp_log2 = 2'd2;
    endcase
  endfunction

  // true when the address does not suit the access width
  function automatic logic is_misaligned(input logic [1:0] lg, input logic [1:0] lsb);
    case (lg)
      2'd1:    is_misaligned = lsb[0];
      2'd2:    is_misaligned = |lsb;
      default: is_misaligned = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ea_offset_gen.sv
module ea_offset_gen
  import ea_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int DISP_W       = 16,
  parameter int MID_DISP_W   = 8,
  parameter int SHORT_DISP_W = 5
) (
  input  logic [2:0]        mode_i,
  input  logic [1:0]        iclass_i,
  input  logic [2:0]        wcode_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   index_val_i,
  output logic [XLEN-1:0]   offset_o,
  output logic [XLEN-1:0]   step_o,
  output logic [1:0]        acc_lg_o
);

  localparam int SHORT_PAD = XLEN - SHORT_DISP_W;
  localparam int MID_PAD   = XLEN - MID_DISP_W;
  localparam int FULL_PAD  = XLEN - DISP_W;

  logic [1:0]      acc_lg;
  logic [1:0]      dsp_lg;
  logic [XLEN-1:0] short_ext;
  logic [XLEN-1:0] mid_ext;
  logic [XLEN-1:0] full_ext;

  always_comb begin
    acc_lg    = access_log2(wcode_i);
    dsp_lg    = disp_log2(iclass_i, wcode_i);
    short_ext = {{SHORT_PAD{1'b0}}, disp_i[SHORT_DISP_W-1:0]};
    mid_ext   = {{MID_PAD{1'b0}}, disp_i[MID_DISP_W-1:0]};
    full_ext  = {{FULL_PAD{1'b0}}, disp_i};
    case (mode_i)
      MODE_REL5:    offset_o = short_ext << acc_lg;
      MODE_REL8:    offset_o = mid_ext << dsp_lg;
      MODE_REL16:   offset_o = full_ext << dsp_lg;
      MODE_INDEXED: offset_o = index_val_i << acc_lg;
      default:      offset_o = '0;
    endcase
    step_o   = XLEN'(1) << acc_lg;
    acc_lg_o = acc_lg;
  end

endmodule

// File: rtl/ea_sum_unit.sv
module ea_sum_unit
  import ea_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      mode_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] offset_i,
  input  logic [XLEN-1:0] step_i,
  output logic [XLEN-1:0] ea_o,
  output logic [XLEN-1:0] wb_data_o,
  output logic            auto_mod_o
);

  logic [XLEN-1:0] sum_v;
  logic [XLEN-1:0] inc_v;
  logic [XLEN-1:0] dec_v;

  assign sum_v = base_i + offset_i;
  assign inc_v = base_i + step_i;
  assign dec_v = base_i - step_i;

  always_comb begin
    ea_o       = sum_v;
    wb_data_o  = '0;
    auto_mod_o = 1'b0;
    case (mode_i)
      MODE_POSTINC: begin
        ea_o       = base_i;
        wb_data_o  = inc_v;
        auto_mod_o = 1'b1;
      end
      MODE_PREDEC: begin
        ea_o       = dec_v;
        wb_data_o  = dec_v;
        auto_mod_o = 1'b1;
      end
      MODE_IND, MODE_RSVD: ea_o = base_i;
      default:             ea_o = sum_v;
    endcase
  end

endmodule

// File: rtl/ea_align_check.sv
module ea_align_check
  import ea_pkg::*;
(
  input  logic [1:0] acc_lg_i,
  input  logic [1:0] ea_lsb_i,
  output logic       misalign_o
);

  assign misalign_o = is_misaligned(acc_lg_i, ea_lsb_i);

endmodule

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
  import ea_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int REG_IDX_W    = 4,
  parameter int DISP_W       = 16,
  parameter int MID_DISP_W   = 8,
  parameter int SHORT_DISP_W = 5,
  parameter int SHORT_REGS   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [2:0]           mode_i,
  input  logic [1:0]           iclass_i,
  input  logic [2:0]           wcode_i,
  input  logic [REG_IDX_W-1:0] base_idx_i,
  input  logic [XLEN-1:0]      base_val_i,
  input  logic [XLEN-1:0]      index_val_i,
  input  logic [DISP_W-1:0]    disp_i,
  output logic                 out_valid_o,
  output logic [XLEN-1:0]      ea_o,
  output logic                 wb_en_o,
  output logic [REG_IDX_W-1:0] wb_idx_o,
  output logic [XLEN-1:0]      wb_data_o,
  output logic                 misalign_o,
  output logic                 illegal_o
);

  localparam logic [REG_IDX_W-1:0] SHORT_LIM = REG_IDX_W'(SHORT_REGS - 1);

  // named internal events, visible to the bound checker
  logic [XLEN-1:0] offset_c;
  logic [XLEN-1:0] step_c;
  logic [1:0]      acc_lg_c;
  logic [XLEN-1:0] ea_c;
  logic [XLEN-1:0] wb_data_c;
  logic            auto_mod_c;
  logic            misalign_c;
  logic            short_bad_c;
  logic            illegal_c;

  ea_offset_gen #(
    .XLEN(XLEN), .DISP_W(DISP_W), .MID_DISP_W(MID_DISP_W), .SHORT_DISP_W(SHORT_DISP_W)
  ) u_offset (
    .mode_i(mode_i), .iclass_i(iclass_i), .wcode_i(wcode_i), .disp_i(disp_i),
    .index_val_i(index_val_i), .offset_o(offset_c), .step_o(step_c), .acc_lg_o(acc_lg_c)
  );

  ea_sum_unit #(.XLEN(XLEN)) u_sum (
    .mode_i(mode_i), .base_i(base_val_i), .offset_i(offset_c), .step_i(step_c),
    .ea_o(ea_c), .wb_data_o(wb_data_c), .auto_mod_o(auto_mod_c)
  );

  ea_align_check u_align (
    .acc_lg_i(acc_lg_c), .ea_lsb_i(ea_c[1:0]), .misalign_o(misalign_c)
  );

  assign short_bad_c = (mode_i == MODE_REL5) && (base_idx_i > SHORT_LIM);
  assign illegal_c   = short_bad_c || (mode_i == MODE_RSVD);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      ea_o        <= '0;
      wb_en_o     <= 1'b0;
      wb_idx_o    <= '0;
      wb_data_o   <= '0;
      misalign_o  <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      out_valid_o <= req_valid_i;
      wb_en_o     <= req_valid_i && auto_mod_c && !illegal_c;
      misalign_o  <= req_valid_i && misalign_c;
      illegal_o   <= req_valid_i && illegal_c;
      if (req_valid_i) begin
        ea_o      <= ea_c;
        wb_idx_o  <= base_idx_i;
        wb_data_o <= wb_data_c;
      end
    end
  end

endmodule

// File: rtl/lsu_ea_gen_chk.sv
module lsu_ea_gen_chk
  import ea_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [2:0]  mode_i,
  input logic [2:0]  wcode_i,
  input logic [3:0]  base_idx_i,
  input logic [31:0] base_val_i,
  input logic        out_valid_o,
  input logic [31:0] ea_o,
  input logic        wb_en_o,
  input logic [31:0] wb_data_o,
  input logic        misalign_o,
  input logic        illegal_o
);

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |=> !out_valid_o && !wb_en_o && !misalign_o && !illegal_o);

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> out_valid_o);

  assert_idle_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !out_valid_o && !wb_en_o && !misalign_o && !illegal_o);

  assert_indirect_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && mode_i == MODE_IND |=> ea_o == $past(base_val_i));

  assert_short_illegal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && mode_i == MODE_REL5 && base_idx_i > 4'd7 |=> illegal_o && !wb_en_o);

  assert_postinc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && mode_i == MODE_POSTINC |=> wb_en_o && ea_o == $past(base_val_i));

  assert_predec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && mode_i == MODE_PREDEC |=> wb_en_o && wb_data_o == ea_o);

  assert_long_align_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && mode_i == MODE_IND && wcode_i == WC_L && base_val_i[1:0] != 2'b00
    |=> misalign_o);

  assert_wb_modes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && mode_i != MODE_POSTINC && mode_i != MODE_PREDEC |=> !wb_en_o);

  assert_reserved_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && mode_i == MODE_RSVD |=> illegal_o);

endmodule

bind lsu_ea_gen lsu_ea_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .mode_i(mode_i),
  .wcode_i(wcode_i), .base_idx_i(base_idx_i), .base_val_i(base_val_i),
  .out_valid_o(out_valid_o), .ea_o(ea_o), .wb_en_o(wb_en_o), .wb_data_o(wb_data_o),
  .misalign_o(misalign_o), .illegal_o(illegal_o)
);

// File: tb/sim_lsu_ea_gen.sv
module sim_lsu_ea_gen;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 24;

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  mode;
    logic [1:0]  cls;
    logic [2:0]  wc;
    logic [3:0]  bidx;
    logic [31:0] base;
    logic [31:0] idx;
    logic [15:0] disp;
    logic        care_ea;
    logic [31:0] ea;
    logic        wben;
    logic [31:0] wbd;
    logic        mis;
    logic        ill;
  } vec_t;

  // req, mode, cls, wc, bidx, base, idx, disp, care, ea, wben, wbd, mis, ill
  localparam vec_t VECS [NVEC] = '{
    '{8'd3,  3'd0, 2'd0, 3'd4, 4'd3,  32'h0000_1000, 32'hDEAD_BEEF, 16'h1234, 1'b1, 32'h0000_1000, 1'b0, 32'h0, 1'b0, 1'b0}, // R3
    '{8'd9,  3'd0, 2'd0, 3'd4, 4'd3,  32'h0000_1002, 32'h0,         16'h0,    1'b1, 32'h0000_1002, 1'b0, 32'h0, 1'b1, 1'b0}, // R9 long
    '{8'd9,  3'd0, 2'd0, 3'd2, 4'd2,  32'h0000_2001, 32'h0,         16'h0,    1'b1, 32'h0000_2001, 1'b0, 32'h0, 1'b1, 1'b0}, // R9 word
    '{8'd4,  3'd2, 2'd0, 3'd2, 4'd1,  32'h0000_2000, 32'h5555_0000, 16'h007F, 1'b1, 32'h0000_20FE, 1'b0, 32'h0, 1'b0, 1'b0}, // R4 xfer W
    '{8'd4,  3'd2, 2'd0, 3'd4, 4'd1,  32'h0000_0000, 32'h0,         16'h01FF, 1'b1, 32'h0000_03FC, 1'b0, 32'h0, 1'b0, 1'b0}, // R4 low 8 bits
    '{8'd4,  3'd3, 2'd0, 3'd4, 4'd1,  32'h0000_0010, 32'h0,         16'hFFFF, 1'b1, 32'h0004_000C, 1'b0, 32'h0, 1'b0, 1'b0}, // R4 zero ext
    '{8'd4,  3'd2, 2'd1, 3'd1, 4'd4,  32'h0000_3001, 32'h0,         16'h0010, 1'b1, 32'h0000_3011, 1'b0, 32'h0, 1'b0, 1'b0}, // R4 UB
    '{8'd4,  3'd2, 2'd1, 3'd3, 4'd4,  32'h0000_3000, 32'h0,         16'h0010, 1'b1, 32'h0000_3020, 1'b0, 32'h0, 1'b0, 1'b0}, // R4 UW
    '{8'd4,  3'd3, 2'd1, 3'd2, 4'd4,  32'h0000_0000, 32'h0,         16'h0001, 1'b1, 32'h0000_0002, 1'b0, 32'h0, 1'b0, 1'b0}, // R4 W
    '{8'd4,  3'd2, 2'd2, 3'd4, 4'd6,  32'h0000_0100, 32'h0,         16'h0004, 1'b1, 32'h0000_0104, 1'b0, 32'h0, 1'b0, 1'b0}, // R4 bit scale 1
    '{8'd4,  3'd2, 2'd2, 3'd0, 4'd6,  32'h0000_0100, 32'h0,         16'h0081, 1'b1, 32'h0000_0181, 1'b0, 32'h0, 1'b0, 1'b0}, // R4 bit byte
    '{8'd4,  3'd3, 2'd3, 3'd0, 4'd6,  32'h0000_0001, 32'h0,         16'h0003, 1'b1, 32'h0000_000D, 1'b0, 32'h0, 1'b0, 1'b0}, // R4 other scale 4
    '{8'd4,  3'd3, 2'd0, 3'd0, 4'd6,  32'hFFFF_FF00, 32'h0,         16'hFFFF, 1'b1, 32'h0000_FEFF, 1'b0, 32'h0, 1'b0, 1'b0}, // R4 wrap
    '{8'd5,  3'd1, 2'd0, 3'd4, 4'd7,  32'h0000_0500, 32'h0,         16'hFFFF, 1'b1, 32'h0000_057C, 1'b0, 32'h0, 1'b0, 1'b0}, // R5 reg 7
    '{8'd5,  3'd1, 2'd0, 3'd4, 4'd8,  32'h0000_0500, 32'h0,         16'h0001, 1'b0, 32'h0,         1'b0, 32'h0, 1'b0, 1'b1}, // R5 reg 8
    '{8'd6,  3'd4, 2'd0, 3'd2, 4'd5,  32'h0000_4000, 32'h0,         16'h0,    1'b1, 32'h0000_4000, 1'b1, 32'h0000_4002, 1'b0, 1'b0}, // R6 W
    '{8'd6,  3'd4, 2'd0, 3'd4, 4'd9,  32'hFFFF_FFFC, 32'h0,         16'h0,    1'b1, 32'hFFFF_FFFC, 1'b1, 32'h0000_0000, 1'b0, 1'b0}, // R6 wrap
    '{8'd6,  3'd4, 2'd0, 3'd4, 4'd2,  32'h0000_4001, 32'h0,         16'h0,    1'b1, 32'h0000_4001, 1'b1, 32'h0000_4005, 1'b1, 1'b0}, // R6 misaligned
    '{8'd7,  3'd5, 2'd0, 3'd4, 4'd0,  32'h0000_4000, 32'h0,         16'h0,    1'b1, 32'h0000_3FFC, 1'b1, 32'h0000_3FFC, 1'b0, 1'b0}, // R7 SP
    '{8'd7,  3'd5, 2'd0, 3'd0, 4'd15, 32'h0000_0000, 32'h0,         16'h0,    1'b1, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R7 wrap
    '{8'd8,  3'd6, 2'd0, 3'd4, 4'd1,  32'h0000_1000, 32'h0000_0010, 16'hFFFF, 1'b1, 32'h0000_1040, 1'b0, 32'h0, 1'b0, 1'b0}, // R8 L
    '{8'd8,  3'd6, 2'd0, 3'd2, 4'd1,  32'h0000_1001, 32'h0000_0002, 16'h0,    1'b1, 32'h0000_1005, 1'b0, 32'h0, 1'b1, 1'b0}, // R8 W
    '{8'd8,  3'd6, 2'd0, 3'd0, 4'd1,  32'hFFFF_FFF0, 32'h0000_0020, 16'h0,    1'b1, 32'h0000_0010, 1'b0, 32'h0, 1'b0, 1'b0}, // R8 wrap
    '{8'd11, 3'd7, 2'd0, 3'd4, 4'd3,  32'h0000_0100, 32'h0,         16'h0,    1'b0, 32'h0,         1'b0, 32'h0, 1'b0, 1'b1}  // R11
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  iclass_i = '0;
  logic [2:0]  wcode_i = '0;
  logic [3:0]  base_idx_i = '0;
  logic [31:0] base_val_i = '0;
  logic [31:0] index_val_i = '0;
  logic [15:0] disp_i = '0;
  logic        out_valid_o;
  logic [31:0] ea_o;
  logic        wb_en_o;
  logic [3:0]  wb_idx_o;
  logic [31:0] wb_data_o;
  logic        misalign_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  lsu_ea_gen u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .mode_i(mode_i),
    .iclass_i(iclass_i), .wcode_i(wcode_i), .base_idx_i(base_idx_i),
    .base_val_i(base_val_i), .index_val_i(index_val_i), .disp_i(disp_i),
    .out_valid_o(out_valid_o), .ea_o(ea_o), .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o),
    .wb_data_o(wb_data_o), .misalign_o(misalign_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid_i = 1'b1;
    mode_i      = v.mode;
    iclass_i    = v.cls;
    wcode_i     = v.wc;
    base_idx_i  = v.bidx;
    base_val_i  = v.base;
    index_val_i = v.idx;
    disp_i      = v.disp;
  endtask

  task automatic expect_vec(input vec_t v);
    string r;
    r = $sformatf("R%0d", v.req);
    chk("R2", "out_valid", 32'(out_valid_o), 32'd1);
    if (v.care_ea) chk(r, "ea", ea_o, v.ea);
    chk(r, "wb_en", 32'(wb_en_o), 32'(v.wben));
    if (v.wben) begin
      chk(r, "wb_data", wb_data_o, v.wbd);
      chk("R10", "wb_idx", 32'(wb_idx_o), 32'(v.bidx));
    end
    chk(r, "misalign", 32'(misalign_o), 32'(v.mis));
    chk(r, "illegal", 32'(illegal_o), 32'(v.ill));
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, during and just after reset
    repeat (3) @(negedge clk_i);
    chk("R1", "out_valid in reset", 32'(out_valid_o), 32'd0);
    chk("R1", "wb_en in reset", 32'(wb_en_o), 32'd0);
    chk("R1", "flags in reset", 32'({misalign_o, illegal_o}), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "out_valid after reset", 32'(out_valid_o), 32'd0);

    // vector table, back to back: each result is read one cycle after its drive
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i]);
      @(negedge clk_i);
      expect_vec(VECS[i]);
    end

    // R2: idle cycle after a flagged request clears valid and every flag
    drive(VECS[17]);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R2", "out_valid idle", 32'(out_valid_o), 32'd0);
    chk("R2", "flags idle", 32'({wb_en_o, misalign_o, illegal_o}), 32'd0);

    // R10: index value has no effect on a relative address
    drive(VECS[3]);
    index_val_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    chk("R10", "ea with index ones", ea_o, 32'h0000_20FE);
    drive(VECS[3]);
    index_val_i = 32'h0000_0000;
    @(negedge clk_i);
    chk("R10", "ea with index zero", ea_o, 32'h0000_20FE);
    chk("R10", "no wb for relative", 32'(wb_en_o), 32'd0);

    // R1: reset in mid-stream clears the outputs
    drive(VECS[15]);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1", "wb_en after mid reset", 32'(wb_en_o), 32'd0);
    chk("R1", "out_valid after mid reset", 32'(out_valid_o), 32'd0);
    rst_ni = 1'b1;
    req_valid_i = 1'b0;
    @(negedge clk_i);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule